// File: doc/BRIEF.md
# Speech Synthesizer Host Command Interface

This block sits between a host processor and the speech engine of a synthesizer chip. The host writes bytes with an active-low write strobe and reads status with an active-low read strobe. While the block is in command mode, each written byte is decoded as a command. After a speak-from-host command, every later written byte is speech data and goes into an internal byte FIFO. A downstream frame parser drains that FIFO one byte at a time.

The command set is small: speak-from-host-data, reset, and no-operation. Every other command code is treated as a no-operation, including the codes that would address an external speech ROM. The block drives a ready line, an interrupt request and three status flags: talking, buffer-low and buffer-empty. These come from the FIFO fill level and the talk state. Pulling both strobes low at the same time resets the whole interface.

Top module: `spk_host_if`

## Requirements
- R1: A write is taken only on the falling edge of `ws_n` while `rs_n` is high. A status read is taken only on the falling edge of `rs_n` while `ws_n` is high. Holding `ws_n` low for several cycles counts as one write.
- R2: In command mode, byte bits [6:4] select the command: 3'b110 is speak-from-host, 3'b111 is reset, and every other value is a no-operation. A no-operation leaves the FIFO, the talk state and the mode unchanged.
- R3: Speak-from-host clears the FIFO, sets a pending-talk state and enters data mode. In data mode, every written byte is pushed into the FIFO and is not decoded as a command.
- R4: `talk_status` rises one cycle after `buf_low` deasserts while talk is pending. A `talk_end` pulse while talking drops `talk_status` and returns the block to command mode.
- R5: `buf_empty` is high exactly when the FIFO holds 0 bytes. `buf_low` is high exactly when the FIFO holds fewer than DEPTH/2 bytes.
- R6: The FIFO is first-in first-out. `cons_data` shows the oldest byte while `cons_avail` is high, and a `cons_pop` pulse removes that byte.
- R7: In data mode with DEPTH bytes stored, `host_ready` is low and written bytes are dropped. `host_ready` returns high once a byte is popped.
- R8: Any change of `buf_low` or `talk_status` sets `host_irq` one cycle later. While `rs_n` is low, `host_dout` = {talk_status, buf_low, buf_empty, 5'b0}. A status read clears `host_irq`, unless a new flag change sets it in the same cycle.
- R9: The reset command clears talk, the FIFO and `host_irq`, and returns the block to command mode.
- R10: While `ws_n` and `rs_n` are both low, the block is held in the R9 reset state. Releasing the strobes one after the other produces no write and no read.
- R11: After `rst_n` is released, the block is in command mode, the FIFO is empty, `host_ready` is high, and `host_irq` and `talk_status` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_n | input | 1 | Host write strobe, active low |
| rs_n | input | 1 | Host read strobe, active low |
| host_din | input | 8 | Host write byte |
| host_dout | output | 8 | Status byte while `rs_n` is low, otherwise 0 |
| host_ready | output | 1 | High when a write can be accepted |
| host_irq | output | 1 | Interrupt request |
| buf_low | output | 1 | FIFO below half full |
| buf_empty | output | 1 | FIFO empty |
| talk_status | output | 1 | Speech in progress |
| cons_pop | input | 1 | Parser removes the head byte |
| cons_data | output | 8 | FIFO head byte |
| cons_avail | output | 1 | FIFO holds at least one byte |
| talk_end | input | 1 | Parser reports end of speech |

## Verification
The assertions assume that the strobes are synchronous to `clk` and that the parser pulses `cons_pop` only while `cons_avail` is high. They also assume `talk_end` is raised only while talking. The bench drives every input on the falling clock edge. It pops only bytes it knows are stored, and raises `talk_end` only after talk has started. Strobe overlap is driven only in the deliberate both-low reset test.

// File: rtl/spk_pkg.sv
package spk_pkg;
  typedef enum logic [1:0] {CMD_NOP, CMD_SPEAK_EXT, CMD_RESET} cmd_e;
  typedef enum logic {MODE_CMD, MODE_DATA} mode_e;

  // Command field is byte bits [6:4]
  function automatic cmd_e decode_cmd(input logic [7:0] b);
    case (b[6:4])
      3'b110:  return CMD_SPEAK_EXT;
      3'b111:  return CMD_RESET;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic talk, input logic low,
                                             input logic empty);
    return {talk, low, empty, 5'b00000};
  endfunction

  // Low mark: fewer than half the depth
  function automatic logic below_half(input int unsigned count, input int unsigned depth);
    return count < (depth / 2);
  endfunction
endpackage

// File: rtl/spk_strobe_dec.sv
module spk_strobe_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_n,
  input  logic rs_n,
  output logic wr_evt,
  output logic rd_evt,
  output logic both_low
);
  logic ws_q, rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= 1'b1;
      rs_q <= 1'b1;
    end else begin
      ws_q <= ws_n;
      rs_q <= rs_n;
    end
  end

  assign both_low = !ws_n && !rs_n;
  assign wr_evt   = !ws_n && ws_q && rs_n;
  assign rd_evt   = !rs_n && rs_q && ws_n;

  // R1
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
  // R1
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> !rd_evt);
endmodule

// File: rtl/spk_byte_fifo.sv
module spk_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST    = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == DEPTH_C);
  assign empty   = (count == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == $past(count)));
  // R3
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/spk_talk_ctrl.sv
module spk_talk_ctrl
  import spk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       both_low,
  input  logic       wr_evt,
  input  logic       rd_evt,
  input  logic [7:0] din,
  input  logic       buf_low,
  input  logic       talk_end,
  output logic       fifo_clr,
  output logic       fifo_push,
  output logic       in_data,
  output logic       talk,
  output logic       irq
);
  mode_e mode;
  cmd_e  cmd;
  logic  pend, prev_low, prev_talk;
  logic  cmd_wr, speak_hit, reset_hit, hard, flag_change, talk_start;

  assign cmd         = decode_cmd(din);
  assign cmd_wr      = wr_evt && (mode == MODE_CMD);
  assign speak_hit   = cmd_wr && (cmd == CMD_SPEAK_EXT);
  assign reset_hit   = cmd_wr && (cmd == CMD_RESET);
  assign hard        = both_low || reset_hit;
  assign fifo_clr    = hard || speak_hit;
  assign fifo_push   = wr_evt && (mode == MODE_DATA);
  assign in_data     = (mode == MODE_DATA);
  assign flag_change = (buf_low != prev_low) || (talk != prev_talk);
  assign talk_start  = pend && !buf_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_CMD; pend <= 1'b0; talk <= 1'b0; irq <= 1'b0;
      prev_low <= 1'b1; prev_talk <= 1'b0;
    end else if (hard) begin
      mode <= MODE_CMD; pend <= 1'b0; talk <= 1'b0; irq <= 1'b0;
      prev_low <= 1'b1; prev_talk <= 1'b0;
    end else begin
      prev_low  <= buf_low;
      prev_talk <= talk;
      if (speak_hit) begin
        mode <= MODE_DATA;
        pend <= 1'b1;
      end else if (talk_start) begin
        talk <= 1'b1;
        pend <= 1'b0;
      end else if (talk && talk_end) begin
        talk <= 1'b0;
        mode <= MODE_CMD;
      end
      if (flag_change)  irq <= 1'b1;
      else if (rd_evt)  irq <= 1'b0;
    end
  end

  // R4
  talk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (talk_start && !hard && !speak_hit) |=> talk);
  // R4
  talk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (talk && talk_end && !hard) |=> (!talk && mode == MODE_CMD));
  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_change && !hard) |=> irq);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !flag_change) |=> !irq);
  // R9
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> (!talk && !irq && mode == MODE_CMD));
  // R2
  nop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == CMD_NOP && !both_low) |=> (mode == MODE_CMD && !talk));
  // R3
  speak_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    speak_hit |=> (mode == MODE_DATA && !talk));
endmodule

// File: rtl/spk_host_if.sv
module spk_host_if
  import spk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ws_n,
  input  logic       rs_n,
  input  logic [7:0] host_din,
  output logic [7:0] host_dout,
  output logic       host_ready,
  output logic       host_irq,
  output logic       buf_low,
  output logic       buf_empty,
  output logic       talk_status,
  input  logic       cons_pop,
  output logic [7:0] cons_data,
  output logic       cons_avail,
  input  logic       talk_end
);
  logic          wr_evt, rd_evt, both_low;
  logic          fifo_clr, fifo_push, fifo_full, in_data;
  logic [CW-1:0] fill;

  spk_strobe_dec u_strobe (
    .clk, .rst_n, .ws_n, .rs_n,
    .wr_evt, .rd_evt, .both_low
  );

  spk_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk, .rst_n,
    .clr   (fifo_clr),
    .push  (fifo_push),
    .din   (host_din),
    .pop   (cons_pop),
    .dout  (cons_data),
    .count (fill),
    .full  (fifo_full),
    .empty (buf_empty)
  );

  assign buf_low = below_half(int'(fill), DEPTH);

  spk_talk_ctrl u_ctrl (
    .clk, .rst_n, .both_low, .wr_evt, .rd_evt,
    .din       (host_din),
    .buf_low,
    .talk_end,
    .fifo_clr,
    .fifo_push,
    .in_data,
    .talk      (talk_status),
    .irq       (host_irq)
  );

  assign cons_avail = !buf_empty;
  assign host_ready = !(in_data && fifo_full);
  assign host_dout  = !rs_n ? pack_status(talk_status, buf_low, buf_empty) : 8'h00;

  // R10
  both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    both_low |=> (!cons_avail && !host_irq && !talk_status && host_ready));
  // R7
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ready && cons_pop && !wr_evt && !both_low) |=> host_ready);
endmodule

// File: tb/tb_spk_host_if.sv
`timescale 1ns/1ps
module tb_spk_host_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ws_n = 1'b1, rs_n = 1'b1;
  logic [7:0] host_din = 8'h00;
  logic [7:0] host_dout, cons_data;
  logic       host_ready, host_irq, buf_low, buf_empty, talk_status, cons_avail;
  logic       cons_pop = 1'b0, talk_end = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  spk_host_if dut (
    .clk, .rst_n, .ws_n, .rs_n, .host_din, .host_dout, .host_ready, .host_irq,
    .buf_low, .buf_empty, .talk_status, .cons_pop, .cons_data, .cons_avail, .talk_end
  );

  // {expect data mode, command byte}: bits [6:4] walk 000..111
  localparam logic [8:0] CMD_VEC [8] = '{
    {1'b0, 8'h0F}, {1'b0, 8'h9A}, {1'b0, 8'h23}, {1'b0, 8'hB1},
    {1'b0, 8'h4C}, {1'b0, 8'hD5}, {1'b1, 8'h60}, {1'b0, 8'hF8}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); host_din = b; ws_n = 1'b0;
    @(negedge clk); ws_n = 1'b1;
  endtask

  task automatic rd_status(output logic [7:0] s);
    @(negedge clk); rs_n = 1'b0;
    #1 s = host_dout;
    @(negedge clk); rs_n = 1'b1;
  endtask

  task automatic pop_one();
    @(negedge clk); cons_pop = 1'b1;
    @(negedge clk); cons_pop = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    check(host_ready && !host_irq && !talk_status && buf_empty && buf_low && !cons_avail,
          "R11 reset flags", {host_ready, host_irq, talk_status, buf_empty, buf_low, cons_avail},
          6'b100110);

    // R2 / R3 command table walk
    for (int i = 0; i < 8; i++) begin
      do_reset();
      wr_byte(CMD_VEC[i][7:0]);
      wr_byte(8'h23);
      check(cons_avail == CMD_VEC[i][8], "R2 command decode", cons_avail, CMD_VEC[i][8]);
      if (CMD_VEC[i][8])
        check(cons_data == 8'h23, "R3 data byte stored", cons_data, 8'h23);
      else
        check(!talk_status && host_ready, "R2 no-op leaves state", talk_status, 0);
    end

    // R1 long write strobe counts once
    do_reset();
    wr_byte(8'h60);
    @(negedge clk); host_din = 8'h42; ws_n = 1'b0;
    idle(3); ws_n = 1'b1;
    idle(1);
    check(cons_avail && cons_data == 8'h42, "R1 held strobe stored", cons_data, 8'h42);
    pop_one();
    check(!cons_avail, "R1 one write per strobe", cons_avail, 0);

    // R8 status read while idle pending
    rd_status(st);
    check(st == 8'h60, "R8 status pending", st, 8'h60);
    check(!host_irq, "R8 no irq without change", host_irq, 0);

    // R4 / R5 fill to half
    for (int k = 0; k < 8; k++) begin
      wr_byte(8'h10 + 8'(k));
      if (k == 6) check(buf_low, "R5 low at 7 bytes", buf_low, 1);
    end
    check(!buf_low && !buf_empty, "R5 half reached", {buf_low, buf_empty}, 0);
    idle(2);
    check(talk_status, "R4 talk starts", talk_status, 1);
    check(host_irq, "R8 irq on flag change", host_irq, 1);
    rd_status(st);
    check(st == 8'h80, "R8 status talking", st, 8'h80);
    idle(1);
    check(!host_irq, "R8 read clears irq", host_irq, 0);

    // R7 full
    for (int k = 8; k < 16; k++) wr_byte(8'h10 + 8'(k));
    check(!host_ready, "R7 ready low when full", host_ready, 0);
    wr_byte(8'hEE);
    check(cons_data == 8'h10, "R6 head is oldest", cons_data, 8'h10);
    pop_one();
    check(host_ready, "R7 ready after pop", host_ready, 1);
    for (int k = 1; k < 14; k++) begin
      check(cons_data == 8'h10 + 8'(k), "R6 fifo order", cons_data, 8'h10 + 8'(k));
      pop_one();
    end
    check(cons_data == 8'h1E, "R7 extra byte dropped", cons_data, 8'h1E);

    // R4 talk end returns to command mode, leftover 2 bytes stay
    @(negedge clk); talk_end = 1'b1;
    @(negedge clk); talk_end = 1'b0;
    check(!talk_status, "R4 talk ends", talk_status, 0);
    idle(2);
    check(host_irq, "R8 irq on talk drop", host_irq, 1);
    wr_byte(8'h23);
    check(cons_avail && cons_data == 8'h1E, "R2 no-op keeps fifo", cons_data, 8'h1E);
    wr_byte(8'h70);
    idle(1);
    check(!cons_avail && !host_irq && !talk_status, "R9 reset command",
          {cons_avail, host_irq, talk_status}, 0);

    // R10 both strobes low
    wr_byte(8'h60);
    for (int k = 0; k < 9; k++) wr_byte(8'h30 + 8'(k));
    idle(2);
    @(negedge clk); ws_n = 1'b0; rs_n = 1'b0; host_din = 8'h77;
    idle(2); rs_n = 1'b1;
    idle(1); ws_n = 1'b1;
    idle(1);
    check(!cons_avail && !talk_status && !host_irq && host_ready, "R10 both-low reset",
          {cons_avail, talk_status, host_irq, host_ready}, 4'b0001);
    wr_byte(8'h60);
    wr_byte(8'h55);
    check(cons_avail && cons_data == 8'h55, "R10 command mode restored", cons_data, 8'h55);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule